// File: doc/BRIEF.md
# T3 Payload AIS and Idle Detector

This block watches the payload bits of a framed DS3 stream and reports whether the far end is sending an alarm indication signal (AIS) or an idle signal. An upstream framer hands over one information bit per strobe and flags the first bit of each 84-bit information field. For each field the block counts how many bits disagree with two phase-aligned reference patterns. A field whose count stays below a small limit is a match for that pattern. The per-field verdicts are then integrated over a long run of consecutive fields to set and to clear two sticky status flags.

The framer also passes the C bits, each tagged with its subframe number and its position (0..2) inside the subframe. Every group of three is majority-voted. A majority of 1 in any subframe spoils an AIS run. A majority of 1 in subframe 3 spoils an idle run. While the framer reports loss of framing, every run counter and every partial field is discarded, and both flags keep their value.

The payload bit input and the C-bit input are valid-only streams, and the block is always ready. A beat is taken on every rising clock edge where its valid is high and framing is good. No back-pressure exists, so the framer never has to hold a beat. The two flags are plain level outputs.

Top module: `t3_payload_alarm_det`

## Requirements
- R1: After reset both `ais_flag` and `idle_flag` are 0.
- R2: A field is compared bit by bit from the beat that carries `fld_start` (bit index 0) against the AIS reference, which is 1 at even indices and 0 at odd indices. The field matches when fewer than ERR_LIMIT (4) of its FIELD_BITS (84) bits differ.
- R3: `ais_flag` rises after PERSIST consecutive matching AIS fields (1024 by default). It becomes visible on the second rising edge after the last bit of the deciding field.
- R4: `ais_flag` falls after PERSIST consecutive AIS-mismatching fields, with the same two-edge latency.
- R5: The idle reference is 1 at indices where index mod 4 is 0 or 1, and 0 elsewhere. Using the same error limit, `idle_flag` sets after PERSIST consecutive matching fields and clears after PERSIST consecutive mismatching fields.
- R6: C bits come in groups of three per subframe, at positions 0, 1, 2. When position 2 arrives, the group's majority is 1 if at least two of the three bits are 1. A majority of 1 in any subframe restarts the AIS set run. Only subframe 3 restarts the idle set run. A group with a single 1 has no effect.
- R7: A field with the opposite verdict restarts the run toward the other flag state. The flag holds its present value until a full run completes.
- R8: When a C-bit majority of 1 and a matching field verdict for the same flag fall in the same cycle, the C-bit event wins: the field is not counted and the set run restarts at zero.
- R9: While `frame_ok` is 0, payload and C-bit beats are ignored, all run counters and any partial field are cleared, and both flags hold their value.
- R10: A new `fld_start` before bit 84 discards the partial field. Payload beats after the 84th bit that come without a new `fld_start` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_ok | input | 1 | Framer reports valid alignment |
| bit_vld | input | 1 | Payload beat valid |
| bit_val | input | 1 | Payload bit value |
| fld_start | input | 1 | Beat is bit 0 of an information field |
| cbit_vld | input | 1 | C-bit beat valid |
| cbit_val | input | 1 | C-bit value |
| cbit_pos | input | 2 | Position of the C bit within its subframe (0..2) |
| cbit_sub | input | 3 | Subframe number of the C bit (1..7) |
| ais_flag | output | 1 | AIS detected |
| idle_flag | output | 1 | Idle signal detected |

## Verification
The two functions that can collide are the C-bit vote and the end-of-field verdict: both reach the run integrators in the same cycle when the third C bit of a group arrives together with the 84th payload bit. The bench provokes this by placing a C group whose majority is 1 so that it ends on the last payload bit of a matching field. A behavioural run model in the bench, where the C-bit event takes precedence, then predicts that the field is not counted and the flag stays one full run behind. The same group placed earlier in the field is also driven, and the model expects the field to count as the first of a new run.

// File: rtl/t3pd_pkg.sv
package t3pd_pkg;
  localparam int unsigned NUM_PAT      = 2;
  localparam int unsigned PAT_AIS      = 0;
  localparam int unsigned PAT_IDLE     = 1;
  localparam int unsigned IDLE_SUBFRM  = 3;

  // Reference bit for a pattern, from the two low bits of the field index.
  function automatic logic ref_bit(input int unsigned pat, input logic [1:0] ph);
    if (pat == PAT_AIS) return ~ph[0];
    return ~ph[1];
  endfunction
endpackage

// File: rtl/t3pd_field_cmp.sv
module t3pd_field_cmp
  import t3pd_pkg::*;
#(
  parameter int unsigned FIELD_BITS = 84,
  parameter int unsigned ERR_LIMIT  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_ok,
  input  logic               bit_vld,
  input  logic               bit_val,
  input  logic               fld_start,
  output logic               res_vld,
  output logic [NUM_PAT-1:0] res_match
);
  localparam int unsigned IDX_W = $clog2(FIELD_BITS);
  localparam int unsigned ERR_W = $clog2(FIELD_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIELD_BITS - 1);

  logic [IDX_W-1:0] pos_q;
  logic             active_q;
  logic [IDX_W-1:0] cur_idx;
  logic             take;
  logic             last;
  logic             res_vld_q;
  logic [NUM_PAT-1:0] match_q;

  assign cur_idx = fld_start ? '0 : pos_q;
  assign take    = frame_ok && bit_vld && (fld_start || active_q);
  assign last    = take && (cur_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      active_q <= 1'b0;
    end else if (!frame_ok) begin
      pos_q    <= '0;
      active_q <= 1'b0;
    end else if (take) begin
      if (last) begin
        pos_q    <= '0;
        active_q <= 1'b0;
      end else begin
        pos_q    <= cur_idx + IDX_W'(1);
        active_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_vld_q <= 1'b0;
    else        res_vld_q <= last;
  end

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] err_next;
    logic             miss;

    assign miss     = bit_val != ref_bit(p, cur_idx[1:0]);
    assign err_next = (fld_start ? '0 : err_q) + ERR_W'(miss);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        err_q      <= '0;
        match_q[p] <= 1'b0;
      end else if (!frame_ok) begin
        err_q <= '0;
      end else if (take) begin
        err_q <= last ? '0 : err_next;
        if (last) match_q[p] <= err_next < ERR_W'(ERR_LIMIT);
      end
    end

    assert_err_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_q <= ERR_W'(FIELD_BITS));
  end

  assign res_vld   = res_vld_q;
  assign res_match = match_q;

  assert_single_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_q |=> !res_vld_q);
  assert_no_result_offline_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> !res_vld_q);
endmodule

// File: rtl/t3pd_cbit_vote.sv
module t3pd_cbit_vote
  import t3pd_pkg::*;
#(
  parameter int unsigned C_PER_SUB = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_ok,
  input  logic                         cbit_vld,
  input  logic                         cbit_val,
  input  logic [$clog2(C_PER_SUB)-1:0] cbit_pos,
  input  logic [2:0]                   cbit_sub,
  output logic                         bad_any,
  output logic                         bad_idle
);
  localparam int unsigned POS_W = $clog2(C_PER_SUB);
  localparam int unsigned ONE_W = $clog2(C_PER_SUB + 1);
  localparam int unsigned MAJ   = C_PER_SUB / 2 + 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(C_PER_SUB - 1);

  logic [ONE_W-1:0] ones_q;
  logic [ONE_W-1:0] ones_next;
  logic             take;
  logic             maj_vld_q;
  logic             maj_one_q;
  logic [2:0]       sub_q;

  assign take      = frame_ok && cbit_vld;
  assign ones_next = ((cbit_pos == '0) ? '0 : ones_q) + ONE_W'(cbit_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q    <= '0;
      maj_vld_q <= 1'b0;
      maj_one_q <= 1'b0;
      sub_q     <= '0;
    end else if (!frame_ok) begin
      ones_q    <= '0;
      maj_vld_q <= 1'b0;
    end else begin
      maj_vld_q <= 1'b0;
      if (take && cbit_pos <= LAST_POS) begin
        ones_q <= ones_next;
        if (cbit_pos == LAST_POS) begin
          maj_vld_q <= 1'b1;
          maj_one_q <= ones_next >= ONE_W'(MAJ);
          sub_q     <= cbit_sub;
        end
      end
    end
  end

  assign bad_any  = maj_vld_q && maj_one_q;
  assign bad_idle = bad_any && (sub_q == 3'(IDLE_SUBFRM));

  assert_vote_after_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    maj_vld_q |-> $past(frame_ok && cbit_vld && cbit_pos == LAST_POS));
  assert_idle_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_idle |-> bad_any);
endmodule

// File: rtl/t3pd_persist.sv
module t3pd_persist #(
  parameter int unsigned PERSIST = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_ok,
  input  logic res_vld,
  input  logic match,
  input  logic cbad,
  output logic flag
);
  localparam int unsigned CNT_W = (PERSIST > 2) ? $clog2(PERSIST) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

  logic [CNT_W-1:0] set_q;
  logic [CNT_W-1:0] clr_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      clr_q  <= '0;
      flag_q <= 1'b0;
    end else if (!frame_ok) begin
      set_q <= '0;
      clr_q <= '0;
    end else if (res_vld) begin
      if (match) begin
        clr_q <= '0;
        if (cbad)                set_q  <= '0;
        else if (set_q == LAST)  flag_q <= 1'b1;
        else                     set_q  <= set_q + CNT_W'(1);
      end else begin
        set_q <= '0;
        if (clr_q == LAST) flag_q <= 1'b0;
        else               clr_q  <= clr_q + CNT_W'(1);
      end
    end else if (cbad) begin
      set_q <= '0;
    end
  end

  assign flag = flag_q;

  assert_set_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(frame_ok && res_vld && match && !cbad));
  assert_clear_needs_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(frame_ok && res_vld && !match));
  assert_opposite_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && res_vld && !match) |=> (set_q == '0));
  assert_cbad_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && cbad) |=> (set_q == '0));
  assert_offline_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> ($stable(flag_q) && set_q == '0 && clr_q == '0));
endmodule

// File: rtl/t3_payload_alarm_det.sv
module t3_payload_alarm_det
  import t3pd_pkg::*;
#(
  parameter int unsigned FIELD_BITS = 84,
  parameter int unsigned ERR_LIMIT  = 4,
  parameter int unsigned PERSIST    = 1024,
  parameter int unsigned C_PER_SUB  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_ok,
  input  logic                         bit_vld,
  input  logic                         bit_val,
  input  logic                         fld_start,
  input  logic                         cbit_vld,
  input  logic                         cbit_val,
  input  logic [$clog2(C_PER_SUB)-1:0] cbit_pos,
  input  logic [2:0]                   cbit_sub,
  output logic                         ais_flag,
  output logic                         idle_flag
);
  logic               res_vld;
  logic [NUM_PAT-1:0] res_match;
  logic [NUM_PAT-1:0] cbad_v;
  logic [NUM_PAT-1:0] flag_v;
  logic               bad_any;
  logic               bad_idle;

  t3pd_field_cmp #(.FIELD_BITS(FIELD_BITS), .ERR_LIMIT(ERR_LIMIT)) u_cmp (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok),
    .bit_vld(bit_vld), .bit_val(bit_val), .fld_start(fld_start),
    .res_vld(res_vld), .res_match(res_match)
  );

  t3pd_cbit_vote #(.C_PER_SUB(C_PER_SUB)) u_vote (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok),
    .cbit_vld(cbit_vld), .cbit_val(cbit_val), .cbit_pos(cbit_pos), .cbit_sub(cbit_sub),
    .bad_any(bad_any), .bad_idle(bad_idle)
  );

  assign cbad_v[PAT_AIS]  = bad_any;
  assign cbad_v[PAT_IDLE] = bad_idle;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_run
    t3pd_persist #(.PERSIST(PERSIST)) u_run (
      .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok),
      .res_vld(res_vld), .match(res_match[g]), .cbad(cbad_v[g]),
      .flag(flag_v[g])
    );
  end

  assign ais_flag  = flag_v[PAT_AIS];
  assign idle_flag = flag_v[PAT_IDLE];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!ais_flag && !idle_flag) || !rst_n);
endmodule

// File: tb/tb_t3_payload_alarm_det.sv
module tb_t3_payload_alarm_det;
  localparam int FB = 84;
  localparam int P  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_ok = 1'b0, bit_vld = 1'b0, bit_val = 1'b0, fld_start = 1'b0;
  logic cbit_vld = 1'b0, cbit_val = 1'b0;
  logic [1:0] cbit_pos = '0;
  logic [2:0] cbit_sub = '0;
  logic ais_flag, idle_flag;

  int total = 0, bad = 0;
  int sA = 0, cA = 0, sI = 0, cI = 0;
  logic fA = 1'b0, fI = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  t3_payload_alarm_det #(.FIELD_BITS(FB), .ERR_LIMIT(4), .PERSIST(P), .C_PER_SUB(3)) dut (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok),
    .bit_vld(bit_vld), .bit_val(bit_val), .fld_start(fld_start),
    .cbit_vld(cbit_vld), .cbit_val(cbit_val), .cbit_pos(cbit_pos), .cbit_sub(cbit_sub),
    .ais_flag(ais_flag), .idle_flag(idle_flag)
  );

  // kind 0: AIS reference, 1: idle reference, 2: all zeros; nerr flips at i%12==5
  function automatic logic pat_bit(input int kind, input int i, input int nerr);
    logic b;
    b = (kind == 0) ? (i % 2 == 0) : (kind == 1) ? (i % 4 < 2) : 1'b0;
    if ((i % 12 == 5) && (i / 12 < nerr)) b = ~b;
    return b;
  endfunction

  task automatic check(input string tag, input logic expA, input logic expI);
    total += 2;
    if (ais_flag !== expA) begin
      bad++;
      $display("FAIL %s ais_flag got=%0b exp=%0b", tag, ais_flag, expA);
    end
    if (idle_flag !== expI) begin
      bad++;
      $display("FAIL %s idle_flag got=%0b exp=%0b", tag, idle_flag, expI);
    end
  endtask

  task automatic upd(inout int s, inout int c, inout logic f,
                     input logic m, input logic cb, input logic same);
    if (cb && !same) s = 0;
    if (m) begin
      c = 0;
      if (cb && same) s = 0;
      else if (s == P - 1) f = 1'b1;
      else s++;
    end else begin
      s = 0;
      if (c == P - 1) f = 1'b0;
      else c++;
    end
  endtask

  task automatic quiet();
    bit_vld = 1'b0; fld_start = 1'b0; bit_val = 1'b0; cbit_vld = 1'b0; cbit_val = 1'b0;
  endtask

  // One field with a C-bit group ending at bit cidx (cbad: group majority is 1)
  task automatic run_field(input int kind, input int nerr, input int csub,
                           input logic cbad, input int cidx, input string tag);
    int eA = 0, eI = 0;
    for (int i = 0; i < FB; i++) begin
      logic b;
      b = pat_bit(kind, i, nerr);
      if (b != (i % 2 == 0)) eA++;
      if (b != (i % 4 < 2)) eI++;
    end
    for (int i = 0; i < FB; i++) begin
      @(negedge clk);
      bit_vld = 1'b1; fld_start = (i == 0); bit_val = pat_bit(kind, i, nerr);
      cbit_vld = 1'b0;
      if (i >= cidx - 2 && i <= cidx) begin
        cbit_vld = 1'b1;
        cbit_pos = 2'(i - (cidx - 2));
        cbit_sub = 3'(csub);
        cbit_val = (i == cidx - 2) ? 1'b1 : (i == cidx) ? cbad : 1'b0;
      end
    end
    @(negedge clk);
    quiet();
    if (frame_ok) begin
      upd(sA, cA, fA, eA < 4, cbad, cidx == FB - 1);
      upd(sI, cI, fI, eI < 4, cbad && csub == 3, cidx == FB - 1);
    end
    @(negedge clk);
    check(tag, fA, fI);
  endtask

  task automatic drive_raw(input int n, input logic st, input int kind);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b1; fld_start = st && (i == 0); bit_val = pat_bit(kind, i, 0);
      cbit_vld = 1'b1; cbit_pos = 2'(i % 3); cbit_sub = 3'd3; cbit_val = 1'b1;
    end
    @(negedge clk);
    quiet();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R3 got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1; frame_ok = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 1'b0);

    // Error-count sweep on the AIS pattern: sets, then clears at 4+ errors
    for (int ne = 0; ne <= 7; ne++)
      for (int k = 0; k <= P; k++)
        run_field(0, ne, 1, 1'b0, 40, "R2 R3 R4 ais sweep");

    // Same sweep on the idle pattern
    for (int ne = 0; ne <= 7; ne++)
      for (int k = 0; k <= P; k++)
        run_field(1, ne, 3, 1'b0, 40, "R5 idle sweep");

    // C-bit votes: subframe 1 restarts AIS only, subframe 3 restarts idle
    for (int k = 0; k < P - 1; k++) run_field(0, 1, 2, 1'b0, 30, "R6 ais run");
    run_field(0, 1, 1, 1'b1, 30, "R6 ais cbad sub1");
    for (int k = 0; k < P; k++) run_field(0, 2, 4, 1'b0, 30, "R6 ais rerun");
    for (int k = 0; k < P; k++) run_field(2, 0, 5, 1'b0, 30, "R4 clear");
    for (int k = 0; k < P - 1; k++) run_field(1, 0, 2, 1'b0, 50, "R6 idle run");
    run_field(1, 0, 1, 1'b1, 50, "R6 idle ignores sub1");
    for (int k = 0; k < P - 1; k++) run_field(1, 0, 3, 1'b1, 50, "R6 idle cbad sub3");
    for (int k = 0; k < P; k++) run_field(1, 0, 6, 1'b0, 50, "R6 idle rerun");

    // Same-cycle collision of C vote and field verdict
    for (int k = 0; k < P; k++) run_field(2, 0, 1, 1'b0, 30, "R8 prep");
    for (int k = 0; k < P - 1; k++) run_field(0, 0, 1, 1'b0, 30, "R8 run");
    run_field(0, 0, 1, 1'b1, FB - 1, "R8 same cycle");
    for (int k = 0; k < P - 1; k++) run_field(0, 0, 1, 1'b0, 30, "R8 short run");
    run_field(0, 0, 1, 1'b0, 30, "R8 full run");

    // Opposite verdicts restart runs while flag holds
    for (int k = 0; k < P - 1; k++) run_field(2, 0, 1, 1'b0, 30, "R7 misses");
    run_field(0, 3, 1, 1'b0, 30, "R7 one match");
    for (int k = 0; k < P - 1; k++) run_field(2, 0, 1, 1'b0, 30, "R7 misses again");
    run_field(2, 0, 1, 1'b0, 30, "R7 clear");

    // Framing loss: beats ignored, runs dropped, flags held
    for (int k = 0; k < P - 1; k++) run_field(0, 0, 1, 1'b0, 30, "R9 run");
    @(negedge clk); frame_ok = 1'b0;
    sA = 0; cA = 0; sI = 0; cI = 0;
    drive_raw(FB, 1'b1, 0);
    check("R9 offline hold", fA, fI);
    @(negedge clk); frame_ok = 1'b1;
    for (int k = 0; k < P - 1; k++) run_field(0, 0, 1, 1'b0, 30, "R9 restart");
    run_field(0, 0, 1, 1'b0, 30, "R9 full run");

    // Restart mid-field and stray beats after bit 84
    for (int k = 0; k < P - 1; k++) run_field(2, 0, 1, 1'b0, 30, "R10 prep");
    drive_raw(40, 1'b1, 2);
    check("R10 partial", fA, fI);
    run_field(0, 0, 1, 1'b0, 30, "R10 partial discarded");
    drive_raw(20, 1'b0, 2);
    check("R10 stray beats", fA, fI);
    for (int k = 0; k < P - 1; k++) run_field(1, 0, 1, 1'b0, 30, "R10 idle run");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule